// File: doc/BRIEF.md
# Sequential Multiply-Add Unit

This block computes `a*x + y` one multiplier bit per clock cycle. It uses the right-shift shift-and-add recurrence. A `W`-bit multiplicand, a `W`-bit multiplier and a `W`-bit addend are captured in a single cycle when `start` is seen while the unit is idle. The unit then makes `W` passes through a single `W+1`-bit adder/subtractor, least-significant multiplier bit first. It raises `done` for one cycle, and from then on it presents the `2W`-bit result until the next accepted start.

The addend is not added at the end. It is placed in the upper accumulator at load time, so the recurrence yields the sum with no extra cycle. The multiplier shares its register with the low half of the product: each step shifts it right by one place and fills the freed top bit with a product bit. The `sgn_mode` input selects the operation for each operation:

- With `sgn_mode` high, all three operands are two's complement. The partial sum and the selected multiple are sign-extended by one bit. The last step subtracts the multiple, because the top multiplier bit carries negative weight.
- With `sgn_mode` low, all three operands are unsigned, and the adder's carry-out becomes the top accumulator bit.

Top module: `mac_seq_top`

## Requirements
- R1: With `sgn_mode`=0, `result` equals `a*x + y` with all operands unsigned, as a `2W`-bit unsigned number.
- R2: With `sgn_mode`=1, `result` equals `a*x + y` with all operands two's complement, as a `2W`-bit two's-complement number.
- R3: With `sgn_mode`=0 and `y`=0, `result` equals the plain unsigned product `a*x`.
- R4: Extreme operands give exact results. In signed mode, `a`=`x`=most-negative and `y`=0 gives `2^(2W-2)`. In unsigned mode, all-ones operands give `2^(2W)-2^W`.
- R5: `done` is a one-cycle pulse. It is high in the cycle that follows the `W`-th clock edge after the edge that accepted `start`.
- R6: `busy` rises on the edge that accepts `start` and falls on the edge of the last step.
- R7: `start` while `busy` is high is ignored: the running operation's result is unchanged and no extra `done` pulse follows.
- R8: After `done`, `result` holds its value until the next accepted `start`.
- R9: While reset is held, and right after it, `done`=0, `busy`=0 and `result`=0.
- R10: Operands and mode are captured at the accepted start. Changes to `a`, `x`, `y` or `sgn_mode` during `busy` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin an operation when idle |
| sgn_mode | input | 1 | 1 = two's complement, 0 = unsigned |
| a | input | W | Multiplicand |
| x | input | W | Multiplier |
| y | input | W | Addend |
| result | output | 2W | Product plus addend |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The operation is accepted on the edge at which `start` is sampled with `busy` low. `busy` is due one edge later, and `done` and the final `result` are due `W` edges after that acceptance edge. The bench drives inputs on falling edges and samples on falling edges at exactly those counts. It checks that `done` is still low at every earlier falling edge, and that `done` has dropped again at the falling edge after the pulse. Holding and the ignored-start cases are checked several falling edges after `done`, in cycles where no accepted start could have changed the outputs.

// File: rtl/mac_seq_pkg.sv
package mac_seq_pkg;
  typedef enum logic {
    MODE_UNS = 1'b0,
    MODE_SGN = 1'b1
  } mac_mode_e;
endpackage

// File: rtl/mac_addsub.sv
// One step of the recurrence: widen the accumulator and the selected
// multiple by one bit, then add or subtract them.
module mac_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] mcand,
  input  logic         bit_en,
  input  logic         sgn,
  input  logic         sub,
  output logic [W:0]   sum
);
  logic [W:0] ext_acc;
  logic [W:0] ext_m;

  always_comb begin
    ext_acc = {sgn & acc[W-1], acc};
    ext_m   = bit_en ? {sgn & mcand[W-1], mcand} : '0;
    sum     = sub ? (ext_acc - ext_m) : (ext_acc + ext_m);
  end
endmodule

// File: rtl/mac_seq_ctrl.sv
// Step counter, busy flag and done pulse.
module mac_seq_ctrl #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load_en,
  output logic step_en,
  output logic last_step,
  output logic busy,
  output logic done
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_d, done_d;

  always_comb begin
    load_en   = start & ~busy;
    step_en   = busy;
    last_step = busy & (cnt_q == LAST);
    cnt_d     = cnt_q;
    busy_d    = busy;
    if (load_en) begin
      cnt_d  = '0;
      busy_d = 1'b1;
    end else if (step_en) begin
      cnt_d = cnt_q + CW'(1);
      if (last_step) busy_d = 1'b0;
    end
    done_d = last_step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      busy  <= busy_d;
      done  <= done_d;
    end
  end
endmodule

// File: rtl/mac_seq_top.sv
module mac_seq_top
  import mac_seq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           sgn_mode,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   y,
  output logic [2*W-1:0] result,
  output logic           busy,
  output logic           done
);
  // Reset synchronizer: asserts asynchronously, releases on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic load_en, step_en, last_step;

  mac_seq_ctrl #(.W(W)) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .start     (start),
    .load_en   (load_en),
    .step_en   (step_en),
    .last_step (last_step),
    .busy      (busy),
    .done      (done)
  );

  logic [W-1:0] acc_q, acc_d;
  logic [W-1:0] low_q, low_d;
  logic [W-1:0] mcand_q, mcand_d;
  mac_mode_e    mode_q, mode_d;
  logic [W:0]   step_sum;
  logic         sub_now;

  // Subtract only on the last step of a signed operation with the top
  // multiplier bit set.
  assign sub_now = (mode_q == MODE_SGN) & last_step & low_q[0];

  mac_addsub #(.W(W)) i_addsub (
    .acc    (acc_q),
    .mcand  (mcand_q),
    .bit_en (low_q[0]),
    .sgn    (mode_q == MODE_SGN),
    .sub    (sub_now),
    .sum    (step_sum)
  );

  always_comb begin
    acc_d   = acc_q;
    low_d   = low_q;
    mcand_d = mcand_q;
    mode_d  = mode_q;
    if (load_en) begin
      acc_d   = y;
      low_d   = x;
      mcand_d = a;
      mode_d  = mac_mode_e'(sgn_mode);
    end else if (step_en) begin
      acc_d = step_sum[W:1];
      low_d = {step_sum[0], low_q[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      acc_q   <= '0;
      low_q   <= '0;
      mcand_q <= '0;
      mode_q  <= MODE_UNS;
    end else begin
      acc_q   <= acc_d;
      low_q   <= low_d;
      mcand_q <= mcand_d;
      mode_q  <= mode_d;
    end
  end

  assign result = {acc_q, low_q};
endmodule

// File: rtl/mac_seq_chk.sv
module mac_seq_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [2*W-1:0] result,
  input logic           busy,
  input logic           done
);
  logic [15:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run <= '0;
    else if (busy) busy_run <= busy_run + 16'd1;
    else           busy_run <= '0;
  end

  // R5: done is a single-cycle pulse
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5: done arrives after exactly W busy cycles
  p_done_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy_run == 16'(W)));

  // R6: an accepted start raises busy
  p_busy_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R6: done only after busy falls
  p_busy_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R8: result holds while idle and no start arrives
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(result));
endmodule

bind mac_seq_top mac_seq_chk #(.W(W)) i_mac_seq_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .result (result),
  .busy   (busy),
  .done   (done)
);

// File: tb/test_mac_seq_top.sv
`timescale 1ns/1ps
module test_mac_seq_top;
  localparam int W = 4;
  localparam int N = 1 << W;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic           sgn_mode = 1'b0;
  logic [W-1:0]   a = '0, x = '0, y = '0;
  logic [2*W-1:0] result;
  logic           busy, done;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  mac_seq_top #(.W(W)) i_mac_seq_top (
    .clk(clk), .rst_n(rst_n), .start(start), .sgn_mode(sgn_mode),
    .a(a), .x(x), .y(y), .result(result), .busy(busy), .done(done)
  );

  function automatic logic [2*W-1:0] model(int av, int xv, int yv, bit s);
    int r;
    if (s) begin
      if (av >= N/2) av -= N;
      if (xv >= N/2) xv -= N;
      if (yv >= N/2) yv -= N;
    end
    r = av * xv + yv;
    return (2*W)'(r);
  endfunction

  task automatic check(bit ok, string req, logic [2*W-1:0] act, logic [2*W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Starts at a falling edge; the start is accepted at the next rising edge.
  task automatic run_op(int av, int xv, int yv, bit s, string req, bit timing);
    logic [2*W-1:0] exp;
    exp = model(av, xv, yv, s);
    a = W'(av); x = W'(xv); y = W'(yv); sgn_mode = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (timing) check(busy == 1'b1, "R6 busy after accept", {7'd0, busy}, 1);
    for (int i = 2; i <= W; i++) begin
      @(negedge clk);
      if (timing) check(done == 1'b0, "R5 early done", {7'd0, done}, 0);
    end
    @(negedge clk);
    check(done == 1'b1, "R5 done due", {7'd0, done}, 1);
    check(result == exp, req, result, exp);
    if (timing) begin
      check(busy == 1'b0, "R6 busy fallen", {7'd0, busy}, 0);
      @(negedge clk);
      check(done == 1'b0, "R5 pulse width", {7'd0, done}, 0);
    end
  endtask

  initial begin
    #1_500_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [2*W-1:0] held;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(done == 0 && busy == 0 && result == 0, "R9 in reset", result, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(done == 0 && busy == 0 && result == 0, "R9 after reset", result, 0);

    // R4: extremes
    run_op(N/2, N/2, 0, 1'b1, "R4 signed most-negative squared", 1'b1);
    check(result == (2*W)'(1 << (2*W-2)), "R4 value", result, (2*W)'(1 << (2*W-2)));
    run_op(N-1, N-1, 0, 1'b0, "R4 unsigned all ones", 1'b1);
    run_op(N-1, N-1, N-1, 1'b0, "R4 unsigned all ones plus addend", 1'b1);
    run_op(N/2, N/2, N/2 - 1, 1'b1, "R4 signed max positive result", 1'b1);
    run_op(N/2 - 1, N/2, N/2, 1'b1, "R4 signed max negative result", 1'b1);

    // R3: plain unsigned product
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        run_op(i, j, 0, 1'b0, "R3 unsigned product", 1'b0);

    // R1 and R2: exhaustive multiply-add in both modes
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          for (int k = 0; k < N; k++)
            run_op(i, j, k, s[0], s ? "R2 signed mac" : "R1 unsigned mac", 1'b0);

    // R7 and R10: start pulses and operand changes during busy are ignored
    a = W'(N/2 + 1); x = W'(N - 3); y = W'(5); sgn_mode = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    a = W'(3); x = W'(7); y = W'(1); sgn_mode = 1'b0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (W - 2) @(negedge clk);
    check(done == 1'b1, "R7 done timing kept", {7'd0, done}, 1);
    check(result == model(N/2 + 1, N - 3, 5, 1'b1), "R10 operands captured",
          result, model(N/2 + 1, N - 3, 5, 1'b1));
    held = result;
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R7 no extra operation", {6'd0, busy, done}, 0);

    // R8: result holds while idle
    repeat (5) @(negedge clk);
    check(result == held, "R8 result held", result, held);
    check(done == 1'b0, "R7 no late done", {7'd0, done}, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule